// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This controller runs an external dual-slope integrating converter. It drives a two-bit phase select and reads back one zero-crossing comparator line. After a start pulse it walks the converter through four phases in a fixed order: auto-zero, input integrate, reference de-integrate and integrator zero. It then parks the converter in auto-zero, which is also the idle state.

The lengths of the auto-zero and integrate phases are given in clock ticks on two input buses, which are held stable while a conversion runs. The input polarity is taken from the comparator on the last tick of integration. The de-integrate time is counted in clock ticks up to the comparator's falling edge, and that count is the magnitude. The comparator first passes through a two-stage synchronizer, so the count includes that fixed latency. There are two timeouts. The first ends a de-integrate that runs past twice the integrate length and marks it as overrange. The second ends an integrator-zero phase in which the comparator never returns high and marks it as an error. Every conversion ends with a one-cycle valid pulse, and the sign, magnitude and flags are held until the next conversion completes.

Top module: `dslope_seq`

## Requirements
- R1: The phase select encodes 00 as integrator zero, 01 as auto-zero, 10 as integrate and 11 as de-integrate. A conversion visits 01, 10, 11, 00 in that order, then returns to 01.
- R2: After reset, and between conversions, the block is idle: phase 01, busy low. A start pulse seen while idle begins a conversion. A start pulse seen while busy is ignored and launches no further conversion.
- R3: Auto-zero lasts az_len_i clock cycles and integrate lasts int_len_i cycles. A length of 0 behaves as 1.
- R4: Comparator activity during auto-zero changes neither the phase timing nor the result.
- R5: The sign is the synchronized comparator level on the last integrate cycle (1 = high = positive). Toggles early in integration do not affect it.
- R6: Let n be the clock edge, counted from the de-integrate entry edge as 0, at which cmp_i is first sampled low after being high. With the default two synchronizer stages, the magnitude is n+1 and de-integrate lasts n+2 cycles.
- R7: If no falling edge is seen within 2*int_len_i de-integrate cycles, the block reports overrange = 1 and magnitude = 2*int_len_i, and integrator zero still runs. A falling edge seen on the final allowed cycle wins over overrange.
- R8: Integrator zero is left on the first cycle in which the synchronized comparator is high. If cmp_i rises h cycles into integrator zero, the phase lasts h+3 cycles.
- R9: If the comparator stays low for IZ_TIMEOUT integrator-zero cycles, the block returns to auto-zero and reports the error flag as 1. Otherwise the flag is 0.
- R10: valid_o is high for exactly one cycle, on the first idle cycle after integrator zero. Sign, magnitude and flags are held until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Conversion request, honoured only when idle |
| az_len_i | input | CNT_W | Auto-zero length in cycles |
| int_len_i | input | CNT_W | Integrate length in cycles |
| cmp_i | input | 1 | Asynchronous zero-crossing comparator |
| phase_o | output | 2 | Converter phase select |
| busy_o | output | 1 | Conversion in progress |
| valid_o | output | 1 | One-cycle result strobe |
| sign_o | output | 1 | Input polarity, 1 = positive |
| mag_o | output | CNT_W+1 | De-integrate count |
| ovr_o | output | 1 | De-integrate limit reached |
| iz_err_o | output | 1 | Integrator-zero timeout |

## Verification
The bench targets the following corner cases:
- A falling edge that lands on the very last allowed de-integrate cycle. A design with the wrong priority flags overrange there, or cuts the count one short.
- Comparator noise in auto-zero and early in integration. A sequencer that sampled the sign too early, or that reacted in auto-zero, reports the wrong polarity or wrong phase lengths.
- Zero-length auto-zero, a start pulse while busy, and a comparator that is stuck high or stuck low. Wrong handling shows up in one of three ways: a hung phase, a second unrequested conversion, or a missing or wrong overrange or timeout flag.
- The exact number of integrator-zero cycles is checked. This catches a block that lingers after the comparator returns high.

// File: rtl/dslope_pkg.sv
package dslope_pkg;
  typedef enum logic [1:0] {
    PH_IZ    = 2'b00,
    PH_AZ    = 2'b01,
    PH_INT   = 2'b10,
    PH_DEINT = 2'b11
  } phase_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_AZ,
    ST_INT,
    ST_DEINT,
    ST_IZ
  } state_e;
endpackage

// File: rtl/dslope_sync.sv
module dslope_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmp_i,
  output logic cmp_s_o,
  output logic fall_o
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], cmp_i};
      prev_q <= sh_q[STAGES-1];
    end
  end

  assign cmp_s_o = sh_q[STAGES-1];
  assign fall_o  = prev_q & ~sh_q[STAGES-1];
endmodule

// File: rtl/dslope_tick.sv
module dslope_tick #(
  parameter int W = 17
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic [W-1:0] lim_i,
  output logic [W-1:0] cnt_o,
  output logic         last_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else            cnt_q <= cnt_q + W'(1);
  end

  // limit of 0 acts as 1
  assign last_o = ({1'b0, cnt_q} + (W+1)'(1)) >= {1'b0, lim_i};
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/dslope_seq.sv
module dslope_seq
  import dslope_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int IZ_TIMEOUT  = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] az_len_i,
  input  logic [CNT_W-1:0] int_len_i,
  input  logic             cmp_i,
  output logic [1:0]       phase_o,
  output logic             busy_o,
  output logic             valid_o,
  output logic             sign_o,
  output logic [CNT_W:0]   mag_o,
  output logic             ovr_o,
  output logic             iz_err_o
);
  localparam int MAG_W = CNT_W + 1;
  localparam logic [MAG_W-1:0] IZ_LIM = MAG_W'(IZ_TIMEOUT);

  state_e           state_q, state_d;
  phase_e           phase;
  logic             cmp_s, cmp_fall;
  logic [MAG_W-1:0] cnt, lim, deint_lim;
  logic             cnt_last, cnt_clr;
  logic             sign_ld, fall_ld, ovr_ld, done, done_err;

  logic             sign_wk, ovr_wk;
  logic [MAG_W-1:0] mag_wk;
  logic             sign_q, ovr_q, err_q, valid_q;
  logic [MAG_W-1:0] mag_q;

  dslope_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cmp_i  (cmp_i),
    .cmp_s_o(cmp_s),
    .fall_o (cmp_fall)
  );

  dslope_tick #(.W(MAG_W)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cnt_clr),
    .lim_i  (lim),
    .cnt_o  (cnt),
    .last_o (cnt_last)
  );

  assign deint_lim = {int_len_i, 1'b0};

  always_comb begin
    unique case (state_q)
      ST_AZ:    lim = {1'b0, az_len_i};
      ST_INT:   lim = {1'b0, int_len_i};
      ST_DEINT: lim = deint_lim;
      ST_IZ:    lim = IZ_LIM;
      default:  lim = '0;
    endcase
  end

  always_comb begin
    state_d  = state_q;
    cnt_clr  = 1'b0;
    sign_ld  = 1'b0;
    fall_ld  = 1'b0;
    ovr_ld   = 1'b0;
    done     = 1'b0;
    done_err = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        cnt_clr = 1'b1;
        if (start_i) state_d = ST_AZ;
      end
      ST_AZ: if (cnt_last) begin
        state_d = ST_INT;
        cnt_clr = 1'b1;
      end
      ST_INT: if (cnt_last) begin
        state_d = ST_DEINT;
        cnt_clr = 1'b1;
        sign_ld = 1'b1;
      end
      ST_DEINT: begin
        // edge beats limit on the same cycle
        if (cmp_fall) begin
          state_d = ST_IZ;
          cnt_clr = 1'b1;
          fall_ld = 1'b1;
        end else if (cnt_last) begin
          state_d = ST_IZ;
          cnt_clr = 1'b1;
          ovr_ld  = 1'b1;
        end
      end
      ST_IZ: begin
        if (cmp_s) begin
          state_d = ST_IDLE;
          done    = 1'b1;
        end else if (cnt_last) begin
          state_d  = ST_IDLE;
          done     = 1'b1;
          done_err = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sign_wk <= 1'b0;
      ovr_wk  <= 1'b0;
      mag_wk  <= '0;
      sign_q  <= 1'b0;
      ovr_q   <= 1'b0;
      err_q   <= 1'b0;
      mag_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      state_q <= state_d;
      valid_q <= done;
      if (sign_ld) sign_wk <= cmp_s;
      if (fall_ld) begin
        mag_wk <= cnt;
        ovr_wk <= 1'b0;
      end
      if (ovr_ld) begin
        mag_wk <= deint_lim;
        ovr_wk <= 1'b1;
      end
      if (done) begin
        sign_q <= sign_wk;
        mag_q  <= mag_wk;
        ovr_q  <= ovr_wk;
        err_q  <= done_err;
      end
    end
  end

  always_comb begin
    unique case (state_q)
      ST_INT:   phase = PH_INT;
      ST_DEINT: phase = PH_DEINT;
      ST_IZ:    phase = PH_IZ;
      default:  phase = PH_AZ;
    endcase
  end

  assign phase_o  = phase;
  assign busy_o   = (state_q != ST_IDLE);
  assign valid_o  = valid_q;
  assign sign_o   = sign_q;
  assign mag_o    = mag_q;
  assign ovr_o    = ovr_q;
  assign iz_err_o = err_q;
endmodule

// File: rtl/dslope_seq_chk.sv
module dslope_seq_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cmp_i,
  input logic [CNT_W-1:0] int_len_i,
  input logic [1:0]       phase_o,
  input logic             busy_o,
  input logic             valid_o,
  input logic [CNT_W:0]   mag_o,
  input logic             ovr_o
);
  // R1: only legal phase steps
  a_r1_phase_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o != $past(phase_o)) |->
      (($past(phase_o) == 2'b01 && phase_o == 2'b10) ||
       ($past(phase_o) == 2'b10 && phase_o == 2'b11) ||
       ($past(phase_o) == 2'b11 && phase_o == 2'b00) ||
       ($past(phase_o) == 2'b00 && phase_o == 2'b01)));

  // R2: idle parks in auto-zero
  a_r2_idle_az: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> phase_o == 2'b01);

  // R7: overrange saturates at twice the integrate length
  a_r7_ovr_sat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && ovr_o) |-> mag_o == {int_len_i, 1'b0});

  // R8: synchronized high in integrator zero ends it next edge
  a_r8_iz_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 2'b00 && $past(phase_o) == 2'b00 && $past(cmp_i, 2)) |=> phase_o == 2'b01);

  // R10: single-cycle strobe, only when idle
  a_r10_valid_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  a_r10_valid_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !busy_o);
endmodule

bind dslope_seq dslope_seq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cmp_i    (cmp_i),
  .int_len_i(int_len_i),
  .phase_o  (phase_o),
  .busy_o   (busy_o),
  .valid_o  (valid_o),
  .mag_o    (mag_o),
  .ovr_o    (ovr_o)
);

// File: tb/dslope_seq_bench.sv
module dslope_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 16;
  localparam int IZ_TO      = 64;
  localparam int WATCHDOG   = 100000;
  localparam int NVEC       = 6;
  // az, int, n, negative, iz hold, noise
  localparam int VEC [NVEC][6] = '{
    '{4, 8, 5, 0, 2, 0},
    '{8, 8, 3, 1, 0, 0},
    '{1, 10, 12, 0, 4, 1},
    '{0, 8, 1, 0, 1, 0},
    '{6, 12, 20, 1, 3, 1},
    '{3, 8, 14, 0, 0, 0}
  };

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             start_i = 1'b0;
  logic [CNT_W-1:0] az_len_i = '0;
  logic [CNT_W-1:0] int_len_i = '0;
  logic             cmp_i = 1'b1;
  logic [1:0]       phase_o;
  logic             busy_o, valid_o, sign_o, ovr_o, iz_err_o;
  logic [CNT_W:0]   mag_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  dslope_seq #(.CNT_W(CNT_W), .IZ_TIMEOUT(IZ_TO)) u_dslope_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .az_len_i(az_len_i), .int_len_i(int_len_i), .cmp_i(cmp_i),
    .phase_o(phase_o), .busy_o(busy_o), .valid_o(valid_o),
    .sign_o(sign_o), .mag_o(mag_o), .ovr_o(ovr_o), .iz_err_o(iz_err_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run_conv(input int az, input int it, input int n, input bit neg,
                          input int h, input bit noise, input bit ovr_case,
                          input bit iz_never, input bit poke_start);
    int az_seen = 0, int_seen = 0, de_seen = 0, iz_seen = 0;
    int exp_mag, exp_de, exp_iz;
    bit lvl = !neg;
    exp_mag = ovr_case ? 2*it : n+1;
    exp_de  = ovr_case ? 2*it : n+2;
    exp_iz  = ovr_case ? 1 : (iz_never ? IZ_TO : h+3);
    @(negedge clk_i);
    az_len_i  = CNT_W'(az);
    int_len_i = CNT_W'(it);
    cmp_i     = lvl;
    start_i   = 1'b1;
    @(negedge clk_i);
    start_i   = 1'b0;
    while (phase_o == 2'b01 && busy_o && az_seen < 5000) begin
      if (noise) cmp_i = ~cmp_i;
      az_seen++;
      @(negedge clk_i);
    end
    cmp_i = lvl;
    chk(az_seen == (az == 0 ? 1 : az), "R3/R4", "auto-zero cycles", az_seen, az == 0 ? 1 : az);
    while (phase_o == 2'b10 && int_seen < 5000) begin
      if (noise) cmp_i = (int_seen < 3) ? ~lvl : lvl;
      if (poke_start) start_i = (int_seen == 1);
      int_seen++;
      @(negedge clk_i);
    end
    start_i = 1'b0;
    chk(int_seen == it, "R3", "integrate cycles", int_seen, it);
    chk(phase_o == 2'b11, "R1", "phase after integrate", phase_o, 3);
    while (phase_o == 2'b11 && de_seen < 5000) begin
      if (de_seen == 0 && neg) cmp_i = 1'b1;
      if (!ovr_case && de_seen == n-1) cmp_i = 1'b0;
      de_seen++;
      @(negedge clk_i);
    end
    chk(de_seen == exp_de, ovr_case ? "R7" : "R6", "de-integrate cycles", de_seen, exp_de);
    chk(phase_o == 2'b00, "R1", "phase after de-integrate", phase_o, 0);
    while (phase_o == 2'b00 && iz_seen < 5000) begin
      if (!ovr_case && !iz_never && iz_seen == h) cmp_i = 1'b1;
      iz_seen++;
      @(negedge clk_i);
    end
    chk(iz_seen == exp_iz, iz_never ? "R9" : "R8", "integrator-zero cycles", iz_seen, exp_iz);
    chk(phase_o == 2'b01 && !busy_o, "R1", "back to auto-zero idle", phase_o, 1);
    chk(valid_o == 1'b1, "R10", "valid strobe", valid_o, 1);
    chk(sign_o == !neg, "R5", "sign", sign_o, !neg);
    chk(int'(mag_o) == exp_mag, ovr_case ? "R7" : "R6", "magnitude", int'(mag_o), exp_mag);
    chk(ovr_o == ovr_case, "R7", "overrange flag", ovr_o, ovr_case);
    chk(iz_err_o == iz_never, "R9", "iz error flag", iz_err_o, iz_never);
    @(negedge clk_i);
    chk(valid_o == 1'b0, "R10", "strobe one cycle", valid_o, 0);
    chk(int'(mag_o) == exp_mag, "R10", "magnitude held", int'(mag_o), exp_mag);
    cmp_i = 1'b1;
  endtask

  initial begin
    wait (cyc >= WATCHDOG);
    errors++;
    $display("FAIL R10 watchdog: conversion never completed actual=%0d expected<%0d", cyc, WATCHDOG);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(phase_o == 2'b01, "R2", "reset phase", phase_o, 1);
    chk(busy_o == 1'b0, "R2", "reset busy", busy_o, 0);
    chk(valid_o == 1'b0, "R10", "reset valid", valid_o, 0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    chk(busy_o == 1'b0 && phase_o == 2'b01, "R2", "idle without start", busy_o, 0);

    for (int i = 0; i < NVEC; i++)
      run_conv(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3] != 0,
               VEC[i][4], VEC[i][5] != 0, 1'b0, 1'b0, 1'b0);

    // R7: comparator stuck high, limit 12
    run_conv(4, 6, 0, 1'b0, 0, 1'b0, 1'b1, 1'b0, 1'b0);
    // R9: comparator never returns high in integrator zero
    run_conv(2, 8, 4, 1'b0, 0, 1'b0, 1'b0, 1'b1, 1'b0);
    // R2: start while busy is ignored
    run_conv(3, 9, 6, 1'b1, 1, 1'b1, 1'b0, 1'b0, 1'b1);
    for (int k = 0; k < 5; k++) begin
      chk(busy_o == 1'b0 && phase_o == 2'b01, "R2", "no conversion from busy start", busy_o, 0);
      @(negedge clk_i);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule